// File: doc/BRIEF.md
# Coefficient Scale-and-Shift Quantizer

This block turns the integer transform coefficients of a block-based video encoder into quantized levels. Every coefficient arrives with its row and column inside a 4x4 block, a quantization parameter (qp) from 0 to 51 and a flag telling whether the block is intra or inter predicted. The block strips the sign, multiplies the magnitude by a factor picked from qp and position, adds a rounding offset, shifts right by an amount that grows with qp and finally puts the sign back.

Working on the magnitude makes the division truncate toward zero for both signs. A plain arithmetic shift of a negative two's-complement value would round toward minus infinity instead: -3 shifted right by 2 gives -1 rather than 0. The datapath is a three-stage pipeline that takes one coefficient per clock with no back-pressure. A valid flag travels alongside each coefficient to its level.

Top module: `coef_quantizer`

## Requirements
- R1: While rst_n is low, and at the first rising edge after it is released, out_valid is 0 and out_level is 0.
- R2: out_valid at rising edge n+3 equals in_valid at rising edge n. out_level at edge n+3 is the level of the coefficient presented at edge n, whatever in_valid did on neighbouring cycles.
- R3: The shift amount is 15 + floor(qp/6) for qp in 0..51, so it spans 15..23.
- R4: The factor is chosen by qp mod 6 and a position class. Class A applies when row and column (each 2 bits, 0..3) are both even, class B when both are odd, and class C otherwise. The (A,B,C) factors for qp mod 6 = 0..5 are (13107,5243,8066), (11916,4660,7490), (10082,4194,6554), (9362,3647,5825), (8192,3355,5243) and (7282,2893,4559).
- R5: With in_intra = 1 the rounding offset is floor(2^shift / 3).
- R6: With in_intra = 0 the rounding offset is floor(2^shift / 6).
- R7: |level| = (|coef| * factor + offset) >> shift. A nonzero level carries the sign of the coefficient, so level(-w) = -level(w).
- R8: A zero result leaves as 0, never as a negative value, and a zero coefficient always yields 0.
- R9: The whole 16-bit signed input range, including -32768 and 32767, quantizes without overflow. |out_level| never exceeds 13107.
- R10: One new coefficient may enter every clock cycle, and back-to-back inputs produce back-to-back levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficient on the inputs is valid this cycle |
| in_coef | input | 16 | Signed transform coefficient |
| in_row | input | 2 | Row index of the coefficient in its 4x4 block |
| in_col | input | 2 | Column index of the coefficient in its 4x4 block |
| in_qp | input | 6 | Quantization parameter, 0..51 |
| in_intra | input | 1 | 1 = intra-predicted block, 0 = inter |
| out_valid | output | 1 | out_level is valid this cycle |
| out_level | output | 16 | Signed quantized level |

## Verification
Two functions meet in one cycle: a new coefficient is accepted while an older one is shifted and has its sign restored. Within that same level, a crossing of qp across a multiple of 6 changes both the factor row and the shift. The bench provokes this with unbroken runs of inputs in which qp, sign, position class and the intra flag change on every cycle, mixed with single-cycle gaps in in_valid. A behavioural model kept as a three-entry delay line of expected levels is compared with out_valid and out_level on every clock. A level that leaks into its neighbour, or a shift taken from the wrong cycle, therefore shows up as a mismatch.

// File: rtl/cq_pkg.sv
package cq_pkg;
    localparam int CQ_COEF_W     = 16;
    localparam int CQ_QP_W       = 6;
    localparam int CQ_MF_W       = 14;
    localparam int CQ_SH_W       = 5;
    localparam int CQ_SHIFT_BASE = 15;
    localparam int CQ_QP_MAX     = 51;
    localparam int CQ_N_SHIFT    = CQ_QP_MAX / 6 + 1;

    typedef enum logic [1:0] {
        POS_BOTH_EVEN = 2'd0,
        POS_BOTH_ODD  = 2'd1,
        POS_MIXED     = 2'd2
    } pos_class_e;
endpackage

// File: rtl/cq_qp_split.sv
module cq_qp_split
    import cq_pkg::*;
#(
    parameter int QP_W = CQ_QP_W,
    parameter int SH_W = CQ_SH_W
) (
    input  logic [QP_W-1:0] qp,
    output logic [2:0]      qp_rem,
    output logic [SH_W-1:0] shift
);
    always_comb begin
        qp_rem = 3'(int'(qp) % 6);
        shift  = SH_W'(CQ_SHIFT_BASE + int'(qp) / 6);
    end
endmodule

// File: rtl/cq_factor_rom.sv
module cq_factor_rom
    import cq_pkg::*;
#(
    parameter int MF_W = CQ_MF_W
) (
    input  logic [2:0]      qp_rem,
    input  logic [1:0]      row,
    input  logic [1:0]      col,
    output logic [MF_W-1:0] factor
);
    pos_class_e      pclass;
    logic [MF_W-1:0] f_even, f_odd, f_mixed;

    always_comb begin
        if (!row[0] && !col[0])
            pclass = POS_BOTH_EVEN;
        else if (row[0] && col[0])
            pclass = POS_BOTH_ODD;
        else
            pclass = POS_MIXED;
    end

    always_comb begin
        unique case (qp_rem)
            3'd0: begin f_even = MF_W'(13107); f_odd = MF_W'(5243); f_mixed = MF_W'(8066); end
            3'd1: begin f_even = MF_W'(11916); f_odd = MF_W'(4660); f_mixed = MF_W'(7490); end
            3'd2: begin f_even = MF_W'(10082); f_odd = MF_W'(4194); f_mixed = MF_W'(6554); end
            3'd3: begin f_even = MF_W'(9362);  f_odd = MF_W'(3647); f_mixed = MF_W'(5825); end
            3'd4: begin f_even = MF_W'(8192);  f_odd = MF_W'(3355); f_mixed = MF_W'(5243); end
            3'd5: begin f_even = MF_W'(7282);  f_odd = MF_W'(2893); f_mixed = MF_W'(4559); end
            default: begin f_even = '0; f_odd = '0; f_mixed = '0; end
        endcase
    end

    always_comb begin
        unique case (pclass)
            POS_BOTH_EVEN: factor = f_even;
            POS_BOTH_ODD:  factor = f_odd;
            default:       factor = f_mixed;
        endcase
    end
endmodule

// File: rtl/cq_round_offset.sv
module cq_round_offset
    import cq_pkg::*;
#(
    parameter int PROD_W = 31,
    parameter int SH_W   = CQ_SH_W
) (
    input  logic [SH_W-1:0]   shift,
    input  logic              intra,
    output logic [PROD_W-1:0] offset
);
    logic [PROD_W-1:0] off_intra [CQ_N_SHIFT];
    logic [PROD_W-1:0] off_inter [CQ_N_SHIFT];

    for (genvar k = 0; k < CQ_N_SHIFT; k++) begin : g_off
        localparam longint STEP = longint'(1) << (CQ_SHIFT_BASE + k);
        assign off_intra[k] = PROD_W'(STEP / 3);
        assign off_inter[k] = PROD_W'(STEP / 6);
    end

    always_comb begin
        offset = '0;
        for (int k = 0; k < CQ_N_SHIFT; k++) begin
            if (shift == SH_W'(CQ_SHIFT_BASE + k))
                offset = intra ? off_intra[k] : off_inter[k];
        end
    end
endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer
    import cq_pkg::*;
#(
    parameter int COEF_W = CQ_COEF_W,
    parameter int QP_W   = CQ_QP_W,
    parameter int MF_W   = CQ_MF_W,
    parameter int SH_W   = CQ_SH_W,
    parameter int LVL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [COEF_W-1:0] in_coef,
    input  logic [1:0]        in_row,
    input  logic [1:0]        in_col,
    input  logic [QP_W-1:0]   in_qp,
    input  logic              in_intra,
    output logic              out_valid,
    output logic [LVL_W-1:0]  out_level
);
    localparam int PROD_W = COEF_W + MF_W + 1;

    // stage 0: decode and magnitude
    logic [2:0]        qp_rem;
    logic [SH_W-1:0]   shift_d;
    logic [MF_W-1:0]   factor_d;
    logic [COEF_W-1:0] mag_d;

    cq_qp_split #(.QP_W(QP_W), .SH_W(SH_W)) i_qp_split (
        .qp     (in_qp),
        .qp_rem (qp_rem),
        .shift  (shift_d)
    );

    cq_factor_rom #(.MF_W(MF_W)) i_factor_rom (
        .qp_rem (qp_rem),
        .row    (in_row),
        .col    (in_col),
        .factor (factor_d)
    );

    assign mag_d = in_coef[COEF_W-1] ? (~in_coef + COEF_W'(1)) : in_coef;

    // stage 1 registers
    logic              s1_valid, s1_neg, s1_intra;
    logic [COEF_W-1:0] s1_mag;
    logic [MF_W-1:0]   s1_factor;
    logic [SH_W-1:0]   s1_shift;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_neg    <= 1'b0;
            s1_intra  <= 1'b0;
            s1_mag    <= '0;
            s1_factor <= '0;
            s1_shift  <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_neg    <= in_coef[COEF_W-1];
            s1_intra  <= in_intra;
            s1_mag    <= mag_d;
            s1_factor <= factor_d;
            s1_shift  <= shift_d;
        end
    end

    // stage 1 -> 2: multiply and add rounding offset
    logic [PROD_W-1:0] offset_d;
    logic [PROD_W-1:0] sum_d;

    cq_round_offset #(.PROD_W(PROD_W), .SH_W(SH_W)) i_round_offset (
        .shift  (s1_shift),
        .intra  (s1_intra),
        .offset (offset_d)
    );

    assign sum_d = PROD_W'(s1_mag) * PROD_W'(s1_factor) + offset_d;

    logic              s2_valid, s2_neg;
    logic [PROD_W-1:0] s2_sum;
    logic [SH_W-1:0]   s2_shift;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_neg   <= 1'b0;
            s2_sum   <= '0;
            s2_shift <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_neg   <= s1_neg;
            s2_sum   <= sum_d;
            s2_shift <= s1_shift;
        end
    end

    // stage 2 -> 3: shift and restore sign
    logic [PROD_W-1:0] shifted_d;
    logic [LVL_W-1:0]  lvl_mag_d;
    logic [LVL_W-1:0]  lvl_d;

    always_comb begin
        shifted_d = s2_sum >> s2_shift;
        lvl_mag_d = shifted_d[LVL_W-1:0];
        lvl_d     = s2_neg ? (~lvl_mag_d + LVL_W'(1)) : lvl_mag_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_level <= '0;
        end else begin
            out_valid <= s2_valid;
            out_level <= lvl_d;
        end
    end
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
    parameter int COEF_W = 16,
    parameter int LVL_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [COEF_W-1:0] in_coef,
    input logic              out_valid,
    input logic [LVL_W-1:0]  out_level
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cyc <= 2'd0;
        else if (cyc != 2'd3)
            cyc <= cyc + 2'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_level == '0));

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_sign_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && out_valid && out_level != '0)
        |-> (out_level[LVL_W-1] == $past(in_coef[COEF_W-1], 3)));

    assert_zero_in_zero_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && $past(in_valid, 3) && $past(in_coef, 3) == '0)
        |-> (out_level == '0));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'($signed(out_level)) <= 13107
                    && int'($signed(out_level)) >= -13107));
endmodule

bind coef_quantizer cq_checker i_cq_checker (.*);

// File: tb/test_coef_quantizer.sv
`timescale 1ns/1ps
module test_coef_quantizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_coef = '0;
    logic [1:0]  in_row = '0;
    logic [1:0]  in_col = '0;
    logic [5:0]  in_qp = '0;
    logic        in_intra = 1'b0;
    logic        out_valid;
    logic [15:0] out_level;
    string       cur_tag = "R2";

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    coef_quantizer i_coef_quantizer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
        .in_row(in_row), .in_col(in_col), .in_qp(in_qp), .in_intra(in_intra),
        .out_valid(out_valid), .out_level(out_level)
    );

    function automatic int factor_of(int rem, int cls);
        int t [6][3] = '{'{13107,5243,8066}, '{11916,4660,7490}, '{10082,4194,6554},
                         '{9362,3647,5825},  '{8192,3355,5243},  '{7282,2893,4559}};
        return t[rem][cls];
    endfunction

    function automatic int ref_level(int c, int r, int col, int qp, bit intra);
        longint mag = (c < 0) ? -c : c;
        int qb  = 15 + qp / 6;
        int cls = ((r % 2) == 0 && (col % 2) == 0) ? 0 :
                  ((r % 2) == 1 && (col % 2) == 1) ? 1 : 2;
        longint off = (longint'(1) << qb) / (intra ? 3 : 6);
        longint m = (mag * factor_of(qp % 6, cls) + off) >> qb;
        return (c < 0) ? -int'(m) : int'(m);
    endfunction

    // behavioural model: three-entry delay line
    bit    m_v   [3];
    int    m_lvl [3];
    string m_tag [3];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_v[i] <= 1'b0; m_lvl[i] <= 0; m_tag[i] <= "R1";
            end
        end else begin
            m_v[0]   <= in_valid;
            m_lvl[0] <= ref_level(int'($signed(in_coef)), int'(in_row), int'(in_col),
                                  int'(in_qp), in_intra);
            m_tag[0] <= cur_tag;
            for (int i = 1; i < 3; i++) begin
                m_v[i] <= m_v[i-1]; m_lvl[i] <= m_lvl[i-1]; m_tag[i] <= m_tag[i-1];
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (out_valid !== m_v[2]) begin
                errors++;
                $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, m_v[2]);
            end
            if (m_v[2]) begin
                checks++;
                if (int'($signed(out_level)) != m_lvl[2]) begin
                    errors++;
                    $display("FAIL %s out_level actual %0d expected %0d",
                             m_tag[2], $signed(out_level), m_lvl[2]);
                end
            end
        end
    end

    task automatic send(int c, int r, int col, int qp, bit intra, string tag);
        in_valid = 1'b1; in_coef = 16'(c); in_row = 2'(r); in_col = 2'(col);
        in_qp = 6'(qp); in_intra = intra; cur_tag = tag;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0; in_coef = 16'h5a5a; cur_tag = "R2";
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_level !== 16'h0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %0b/%0d expected 0/0", out_valid, out_level);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R3 R4 R5: qp sweep, all classes, intra
        for (int qp = 0; qp <= 51; qp++) begin
            send(1000, 0, 0, qp, 1'b1, "R3");
            send(1000, 1, 3, qp, 1'b1, "R4");
            send(-777, 2, 1, qp, 1'b1, "R5");
        end
        // R6 inter sweep
        for (int qp = 0; qp <= 51; qp++)
            send(4321, qp % 4, (qp / 4) % 4, qp, 1'b0, "R6");
        // R7 truncation toward zero, sign symmetry
        for (int c = 1; c < 40; c++) begin
            send(-c, 0, 0, 0, 1'b0, "R7");
            send(c, 0, 0, 0, 1'b0, "R7");
        end
        send(-3, 3, 3, 0, 1'b1, "R7");
        // R8 zero input and small negatives rounding to zero
        send(0, 0, 0, 0, 1'b1, "R8");
        send(0, 1, 2, 51, 1'b0, "R8");
        send(-1, 1, 1, 51, 1'b0, "R8");
        send(-2, 0, 1, 30, 1'b1, "R8");
        // R9 extremes
        for (int qp = 0; qp < 6; qp++) begin
            send(-32768, 0, 0, qp, 1'b1, "R9");
            send(32767, 2, 2, qp, 1'b1, "R9");
            send(-32768, 1, 1, qp, 1'b0, "R9");
        end
        // R2 gaps in valid
        send(500, 0, 0, 10, 1'b1, "R2");
        idle(1);
        send(-500, 0, 1, 11, 1'b0, "R2");
        idle(2);
        send(900, 3, 3, 12, 1'b1, "R2");
        idle(4);
        // R10 back-to-back with everything changing
        for (int i = 0; i < 3000; i++) begin
            if ((i % 17) == 16) idle(1);
            else send(int'($signed(16'($urandom))), int'($urandom % 4), int'($urandom % 4),
                      int'($urandom % 52), 1'($urandom), "R10");
        end
        idle(6);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule